// File: doc/BRIEF.md
# Machine-Cycle Clock Generator with Halt and Stop Standby

The block produces the CPU machine-cycle timing from the oscillator clock. A 4-bit control register sets how many oscillator periods make up one machine cycle, and it can put the block into one of two standby states. The CPU clock leaves the block as a one-cycle enable pulse in the oscillator domain. Each pulse marks the end of a machine cycle. A free-running prescaler gives a strobe to the peripherals.

In halt, only the CPU enable is held off. The oscillator and the prescaler keep running. In stop, the oscillator-enable output drops and every counter freezes. An interrupt-release strobe ends either state. After stop, the oscillator is re-enabled, but CPU pulses resume only after a wait-release strobe arrives from the interval timer, which gives the oscillator time to settle. Each exit from standby clears the two standby request bits in the register.

Top module: `mcyc_clkgen`

## Requirements
- R1: Control bits [1:0] set the machine-cycle length. 00 gives 64, 01 gives 8, and both 10 and 11 give 4 oscillator periods. `cpu_en_o` is high for exactly one cycle per machine cycle.
- R2: While `rst_ni` is low, the register reads 0000, `osc_en_o` is 1 and `cpu_en_o` is 0. The first CPU pulse comes 64 oscillator cycles after reset is released.
- R3: A new length takes effect only at a machine-cycle boundary. The machine cycle in progress when the length is written completes at its old length.
- R4: A write with bit 2 = 1 and bit 3 = 0 enters halt. `cpu_en_o` stays 0, while `osc_en_o` stays 1 and `presc_tap_o` keeps pulsing.
- R5: A write with bit 3 = 1 enters stop, and bit 3 wins over bit 2. `osc_en_o`, `cpu_en_o` and `presc_tap_o` all stay 0.
- R6: In halt, `irq_wake_i` ends halt and clears register bits [3:2]. CPU pulses resume within one machine cycle.
- R7: In stop, `irq_wake_i` raises `osc_en_o` on the next cycle and clears bits [3:2]. `cpu_en_o` stays 0 until `bt_wait_i` arrives, and pulses then resume within one machine cycle.
- R8: Register writes made during halt, during stop, or while waiting for `bt_wait_i` are ignored.
- R9: `bt_wait_i` has no effect during halt or stop. `irq_wake_i` has no effect while waiting for `bt_wait_i`.
- R10: While the oscillator is enabled, `presc_tap_o` is a one-cycle strobe every 16 oscillator cycles.
- R11: Asserting reset during standby returns the block to its reset state. The first pulse then follows 64 cycles after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctl_we_i | input | 1 | Control register write strobe |
| ctl_wdata_i | input | 4 | Write data: [1:0] length select, [2] halt request, [3] stop request |
| irq_wake_i | input | 1 | Interrupt release strobe |
| bt_wait_i | input | 1 | Wait-release strobe from the interval timer |
| ctl_o | output | 4 | Current control register value |
| cpu_en_o | output | 1 | One-cycle machine-cycle enable |
| presc_tap_o | output | 1 | Peripheral prescaler strobe |
| osc_en_o | output | 1 | Oscillator enable |

## Verification
The register and the standby flops are both visible at the ports. A standby state that fails to clear therefore shows up as a missing `cpu_en_o` pulse within one machine cycle of the wake strobe, or at most 64 cycles. A stale request bit shows up on `ctl_o` on the cycle after the wake. A divider select latched at the wrong moment shows up as a period of the wrong length: either the interval right after the write or the one after that. A wrong stop-to-wait transition shows up immediately as `osc_en_o` staying low, or as a CPU pulse appearing before `bt_wait_i`.

// File: rtl/mcyc_pkg.sv
package mcyc_pkg;
  localparam int unsigned CTL_W    = 4;
  localparam int unsigned HALT_BIT = 2;
  localparam int unsigned STOP_BIT = 3;

  typedef enum logic [1:0] {
    SEL_SLOW  = 2'b00,
    SEL_MID   = 2'b01,
    SEL_FAST  = 2'b10,
    SEL_FAST2 = 2'b11
  } div_sel_e;

  function automatic int unsigned div_len(div_sel_e s, int unsigned slow,
                                          int unsigned mid, int unsigned fast);
    case (s)
      SEL_SLOW: return slow;
      SEL_MID:  return mid;
      default:  return fast;
    endcase
  endfunction
endpackage

// File: rtl/mcyc_prescaler.sv
module mcyc_prescaler #(
  parameter int unsigned PRESC_LOG2 = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tap_o
);
  logic [PRESC_LOG2-1:0] pcnt_q;
  logic                  tap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pcnt_q <= '0;
      tap_q  <= 1'b0;
    end else if (en_i) begin
      pcnt_q <= pcnt_q + 1'b1;
      tap_q  <= &pcnt_q;
    end else begin
      tap_q  <= 1'b0;  // count frozen while oscillator is off
    end
  end

  assign tap_o = tap_q & en_i;

  AST_TAP_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tap_o |=> !tap_o); // R10
endmodule

// File: rtl/mcyc_divider.sv
module mcyc_divider
  import mcyc_pkg::*;
#(
  parameter int unsigned DIV_SLOW = 64,
  parameter int unsigned DIV_MID  = 8,
  parameter int unsigned DIV_FAST = 4
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     en_i,
  input  logic     run_i,
  input  div_sel_e sel_i,
  output logic     pulse_o
);
  localparam int unsigned CNT_W = $clog2(DIV_SLOW);

  logic [CNT_W-1:0] cnt_q;
  div_sel_e         act_sel_q;
  logic             pulse_q;
  logic             term;

  assign term = (cnt_q == CNT_W'(div_len(act_sel_q, DIV_SLOW, DIV_MID, DIV_FAST) - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      act_sel_q <= SEL_SLOW;
      pulse_q   <= 1'b0;
    end else if (en_i) begin
      pulse_q <= term & run_i;
      if (term) begin
        cnt_q     <= '0;
        act_sel_q <= sel_i;  // new length only at boundary
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else begin
      pulse_q <= 1'b0;
    end
  end

  assign pulse_o = pulse_q & run_i;

  AST_SEL_AT_BOUNDARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !term |=> $stable(act_sel_q)); // R3
  AST_PULSE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |=> !pulse_o); // R1
endmodule

// File: rtl/mcyc_standby.sv
module mcyc_standby (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_i,
  input  logic halt_req_i,
  input  logic stop_req_i,
  input  logic irq_i,
  input  logic btw_i,
  output logic run_o,
  output logic busy_o,
  output logic osc_en_o,
  output logic wake_clr_o
);
  logic halt_q, stop_q, wait_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      halt_q <= 1'b0;
      stop_q <= 1'b0;
      wait_q <= 1'b0;
    end else if (stop_q) begin
      if (irq_i) begin
        stop_q <= 1'b0;
        wait_q <= 1'b1;  // oscillator settles until timer release
      end
    end else if (wait_q) begin
      if (btw_i) wait_q <= 1'b0;
    end else if (halt_q) begin
      if (irq_i) halt_q <= 1'b0;
    end else if (wr_i) begin
      stop_q <= stop_req_i;
      halt_q <= halt_req_i & ~stop_req_i;
    end
  end

  assign busy_o     = halt_q | stop_q | wait_q;
  assign run_o      = ~busy_o;
  assign osc_en_o   = ~stop_q;
  assign wake_clr_o = (halt_q | stop_q) & irq_i;

  AST_ONE_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({halt_q, stop_q, wait_q})); // R5
  AST_HALT_WAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_q && irq_i |=> !halt_q && run_o); // R6
  AST_STOP_TO_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_q && irq_i |=> wait_q && osc_en_o); // R7
  AST_WAIT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wait_q && !btw_i |=> wait_q); // R7
  AST_HALT_IGNORES_BT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_q && !irq_i |=> halt_q); // R9
endmodule

// File: rtl/mcyc_clkgen.sv
module mcyc_clkgen
  import mcyc_pkg::*;
#(
  parameter int unsigned DIV_SLOW   = 64,
  parameter int unsigned DIV_MID    = 8,
  parameter int unsigned DIV_FAST   = 4,
  parameter int unsigned PRESC_LOG2 = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctl_we_i,
  input  logic [CTL_W-1:0] ctl_wdata_i,
  input  logic             irq_wake_i,
  input  logic             bt_wait_i,
  output logic [CTL_W-1:0] ctl_o,
  output logic             cpu_en_o,
  output logic             presc_tap_o,
  output logic             osc_en_o
);
  logic [CTL_W-1:0] ctl_q;
  logic             wr_ok, run, busy, osc_en, wake_clr;

  assign wr_ok = ctl_we_i & ~busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q <= '0;
    end else if (wake_clr) begin
      ctl_q[STOP_BIT] <= 1'b0;
      ctl_q[HALT_BIT] <= 1'b0;
    end else if (wr_ok) begin
      ctl_q <= ctl_wdata_i;
    end
  end

  mcyc_standby u_standby (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (wr_ok),
    .halt_req_i (ctl_wdata_i[HALT_BIT]),
    .stop_req_i (ctl_wdata_i[STOP_BIT]),
    .irq_i      (irq_wake_i),
    .btw_i      (bt_wait_i),
    .run_o      (run),
    .busy_o     (busy),
    .osc_en_o   (osc_en),
    .wake_clr_o (wake_clr)
  );

  mcyc_divider #(
    .DIV_SLOW (DIV_SLOW),
    .DIV_MID  (DIV_MID),
    .DIV_FAST (DIV_FAST)
  ) u_divider (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (osc_en),
    .run_i   (run),
    .sel_i   (div_sel_e'(ctl_q[1:0])),
    .pulse_o (cpu_en_o)
  );

  mcyc_prescaler #(
    .PRESC_LOG2 (PRESC_LOG2)
  ) u_prescaler (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (osc_en),
    .tap_o  (presc_tap_o)
  );

  assign ctl_o    = ctl_q;
  assign osc_en_o = osc_en;

  AST_OSC_OFF_NO_CPU: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !osc_en_o |-> !cpu_en_o && !presc_tap_o); // R5
  AST_WR_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy && !irq_wake_i |=> $stable(ctl_q)); // R8
  AST_WAKE_CLEARS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_clr |=> ctl_q[STOP_BIT:HALT_BIT] == 2'b00); // R6
endmodule

// File: tb/mcyc_clkgen_tb.sv
module mcyc_clkgen_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0;
  logic [3:0] wdata = 4'h0;
  logic       irq = 1'b0;
  logic       btw = 1'b0;
  logic [3:0] ctl;
  logic       cpu_en, tap, osc_en;
  int         total = 0;
  int         bad = 0;

  always #10 clk = ~clk;

  mcyc_clkgen u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ctl_we_i(we), .ctl_wdata_i(wdata),
    .irq_wake_i(irq), .bt_wait_i(btw), .ctl_o(ctl), .cpu_en_o(cpu_en),
    .presc_tap_o(tap), .osc_en_o(osc_en)
  );

  // {select, expected period}
  localparam logic [9:0] VEC [6] = '{
    {2'b10, 8'd4}, {2'b01, 8'd8}, {2'b11, 8'd4},
    {2'b00, 8'd64}, {2'b10, 8'd4}, {2'b01, 8'd8}
  };

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic next_pulse(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!cpu_en && n < 400);
  endtask

  task automatic wr(logic [3:0] d);
    we = 1'b1; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic strobe_irq();
    irq = 1'b1; @(negedge clk); irq = 1'b0;
  endtask

  task automatic strobe_bt();
    btw = 1'b1; @(negedge clk); btw = 1'b0;
  endtask

  // counts pulses on each output over a window
  task automatic observe(int cyc, output int np, output int nt, output int no);
    np = 0; nt = 0; no = 0;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      np += int'(cpu_en); nt += int'(tap); no += int'(osc_en);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n, np, nt, no, cur;
    repeat (3) @(negedge clk);
    chk("R2 ctl in reset", int'(ctl), 0);
    chk("R2 osc_en in reset", int'(osc_en), 1);
    chk("R2 cpu_en in reset", int'(cpu_en), 0);
    rst_n = 1'b1;
    next_pulse(n);
    chk("R2 first pulse", n, 64);

    // R10 prescaler spacing
    while (!tap) @(negedge clk);
    n = 0;
    do begin @(negedge clk); n++; end while (!tap && n < 100);
    chk("R10 tap spacing", n, 16);

    // R1/R3 table walk
    next_pulse(n);
    cur = 64;
    for (int v = 0; v < 6; v++) begin
      wr({2'b00, VEC[v][9:8]});
      next_pulse(n);
      chk("R3 old length completes", n + 1, cur);
      next_pulse(n);
      chk("R1 new period", n, int'(VEC[v][7:0]));
      next_pulse(n);
      chk("R1 period repeat", n, int'(VEC[v][7:0]));
      cur = int'(VEC[v][7:0]);
    end

    // R4 halt (fast select)
    wr(4'b0110);
    observe(40, np, nt, no);
    chk("R4 no cpu in halt", np, 0);
    chk("R4 osc on in halt", no, 40);
    chk("R4 tap runs in halt", int'(nt >= 2), 1);
    chk("R4 ctl halt", int'(ctl), 6);
    wr(4'b0001);
    @(negedge clk);
    chk("R8 write ignored in halt", int'(ctl), 6);
    strobe_bt();
    observe(20, np, nt, no);
    chk("R9 bt ignored in halt", np, 0);
    strobe_irq();
    chk("R6 wake clears req", int'(ctl), 2);
    next_pulse(n);
    chk("R6 resume within cycle", int'(n <= 4), 1);
    next_pulse(n);
    chk("R6 period after wake", n, 4);

    // R5 stop (both bits: stop wins)
    wr(4'b1110);
    chk("R5 osc off", int'(osc_en), 0);
    observe(30, np, nt, no);
    chk("R5 no cpu in stop", np, 0);
    chk("R5 no tap in stop", nt, 0);
    chk("R5 osc stays off", no, 0);
    strobe_bt();
    observe(10, np, nt, no);
    chk("R9 bt ignored in stop", no, 0);
    strobe_irq();
    chk("R7 osc back on", int'(osc_en), 1);
    chk("R7 wake clears req", int'(ctl), 2);
    observe(30, np, nt, no);
    chk("R7 cpu held until bt", np, 0);
    strobe_irq();
    observe(20, np, nt, no);
    chk("R9 irq ignored in wait", np, 0);
    wr(4'b0001);
    @(negedge clk);
    chk("R8 write ignored in wait", int'(ctl), 2);
    strobe_bt();
    next_pulse(n);
    chk("R7 resume after bt", int'(n <= 4), 1);

    // R11 reset during halt
    wr(4'b0100);
    observe(10, np, nt, no);
    chk("R11 halted", np, 0);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R11 ctl reset", int'(ctl), 0);
    chk("R11 osc on", int'(osc_en), 1);
    rst_n = 1'b1;
    next_pulse(n);
    chk("R11 first pulse", n, 64);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule